// File: doc/BRIEF.md
# ATA PIO Device Target

This block plays the drive side of a parallel ATA link in programmed I/O mode. A host reaches its task-file registers through a 2-bit chip-select pair, a 3-bit register address and separate active-low read and write strobes. The host loads a starting block address and a sector count, then issues a read-sectors or write-sectors command. Sector data moves one 16-bit word per strobe through an internal sector buffer. A status register tells the host when the block is busy and when data may be moved.

Behind the buffer sits a small on-chip backing store of `STORE_SECT` sectors of `2**SW_LOG2` words each. A read command first copies sectors from the store into the buffer. A write command fills the buffer from the host and then copies it back once the final word arrives. All inputs are taken to be synchronous to `clk`. A strobe acts once, at the first clock edge that samples it low after it was sampled high.

Top module: `ata_pio_target`

## Requirements
- R1: The register address is `{cs, da}`. 0x10 is the data port and 0x12 the sector count. 0x13, 0x14 and 0x15 supply block-address bits 7:0, 15:8 and 23:16. 0x16 supplies bits 27:24 from its low nibble. A read of 0x17 gives status and a write to 0x17 is a command. A register action happens once for each high-to-low strobe transition, however long the strobe stays low. A read of any address other than 0x10 or 0x17 presents 0.
- R2: After reset the status is 0x50 and `dout` is 0. Status bits: bit 7 busy, bit 6 ready (always 1), bit 4 seek-done (always 1), bit 3 data request, all other bits 0.
- R3: The block address is taken from the task-file registers when a command is issued. Sector k of the transfer lives at store sector (address + k).
- R4: Command 0x20 shows status 0xD0 while it copies the sectors into the buffer, then 0x58. Each data read then returns the next buffer word in order.
- R5: `dout` changes only at a read strobe's falling edge and holds its value while the strobe stays low. After the last word of a read transfer the status returns to 0x50, and further data reads present 0.
- R6: Command 0x30 shows status 0x58 from the next access onward. Each data write stores the next buffer word in order.
- R7: The data write that completes the transfer starts a write-back to the store with status 0xD8. When the write-back ends the status becomes 0x50.
- R8: A transfer has 256 × n words, where n is the sector count clamped to the range 1 to `BUF_SECT` (2 by default). A count of 0 therefore means one sector.
- R9: Store sectors at or beyond `STORE_SECT` (8 by default) read as zeros, and writes to them are dropped.
- R10: Writes to 0x0E, 0x1E and 0x11 and commands other than 0x20 and 0x30 have no effect. While busy, every write strobe and every data read is ignored, and a data read presents 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 2 | Chip-select pair, upper address bits |
| da | input | 3 | Register address within the selected block |
| dior_n | input | 1 | Active-low read strobe |
| diow_n | input | 1 | Active-low write strobe |
| din | input | 16 | Write data from the host |
| dout | output | 16 | Read data to the host, held between read strobes |

## Verification
On every cycle, the assertions check that `dout` moves only at a read falling edge. They also check that the transfer pointers never pass the transfer length and that neither pointer moves while the block is busy. Finally, they check how the data-request flag relates to the busy flag: it is clear during a load, set during a write-back, and set or cleared correctly at the moment the busy flag falls. The bench scenarios alone show that data survives the round trip, that the address fields land where they should, that the sector count is clamped, that out-of-range sectors read as zeros, and that ignored registers and commands leave the status untouched.

// File: rtl/ata_pio_target.sv
module ata_pio_target #(
  parameter int STORE_SECT = 8,
  parameter int BUF_SECT   = 2,
  parameter int SW_LOG2    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cs,
  input  logic [2:0]  da,
  input  logic        dior_n,
  input  logic        diow_n,
  input  logic [15:0] din,
  output logic [15:0] dout
);
  localparam int SW      = 1 << SW_LOG2;
  localparam int BUF_W   = BUF_SECT * SW;
  localparam int STORE_W = STORE_SECT * SW;
  localparam int BAW     = $clog2(BUF_W + 1);
  localparam int BIW     = $clog2(BUF_W);
  localparam int SAW     = $clog2(STORE_W);
  localparam int CW      = $clog2(BUF_SECT + 1);
  localparam int LINW    = 28 + SW_LOG2 + 1;

  localparam logic [4:0] A_DATA = 5'h10;
  localparam logic [4:0] A_CNT  = 5'h12;
  localparam logic [4:0] A_B0   = 5'h13;
  localparam logic [4:0] A_B1   = 5'h14;
  localparam logic [4:0] A_B2   = 5'h15;
  localparam logic [4:0] A_B3   = 5'h16;
  localparam logic [4:0] A_CMD  = 5'h17;

  logic [15:0] store [STORE_W];
  logic [15:0] sbuf  [BUF_W];

  logic [7:0]  cnt_q, b0_q, b1_q, b2_q;
  logic [3:0]  b3_q;
  logic [27:0] lba_q;
  logic        rd_prev, wr_prev;
  logic        busy, drq, dir_wr;
  logic [BAW-1:0] rd_ptr, wr_ptr, len, cp_idx;
  logic [15:0] dout_q;

  logic [4:0]  addr;
  logic        rd_edge, wr_edge;
  logic [CW-1:0] eff_cnt;
  logic [BAW-1:0] new_len;
  logic [LINW-1:0] lin;
  logic        in_range;
  logic [SAW-1:0] st_addr;
  logic [7:0]  status;

  assign addr    = {cs, da};
  assign rd_edge = rd_prev & ~dior_n;
  assign wr_edge = wr_prev & ~diow_n;
  assign status  = {busy, 1'b1, 1'b0, 1'b1, drq, 3'b000};
  assign lin     = {1'b0, lba_q, {SW_LOG2{1'b0}}} + LINW'(cp_idx);
  assign in_range = lin < LINW'(STORE_W);
  assign st_addr = lin[SAW-1:0];
  assign new_len = BAW'(eff_cnt) << SW_LOG2;
  assign dout    = dout_q;

  always_comb begin
    if (cnt_q == 8'd0)                eff_cnt = CW'(1);
    else if (cnt_q > 8'(BUF_SECT))    eff_cnt = CW'(BUF_SECT);
    else                              eff_cnt = CW'(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; b0_q <= '0; b1_q <= '0; b2_q <= '0; b3_q <= '0;
      lba_q <= '0;
      rd_prev <= 1'b1; wr_prev <= 1'b1;
      busy <= 1'b0; drq <= 1'b0; dir_wr <= 1'b0;
      rd_ptr <= '0; wr_ptr <= '0; len <= '0; cp_idx <= '0;
      dout_q <= '0;
    end else begin
      rd_prev <= dior_n;
      wr_prev <= diow_n;
      if (busy) begin
        cp_idx <= cp_idx + BAW'(1);
        if (cp_idx == len - BAW'(1)) begin
          busy <= 1'b0;
          drq  <= ~dir_wr;
        end
      end else if (wr_edge) begin
        case (addr)
          A_CNT: cnt_q <= din[7:0];
          A_B0:  b0_q  <= din[7:0];
          A_B1:  b1_q  <= din[7:0];
          A_B2:  b2_q  <= din[7:0];
          A_B3:  b3_q  <= din[3:0];
          A_DATA: if (drq && dir_wr) begin
            wr_ptr <= wr_ptr + BAW'(1);
            if (wr_ptr == len - BAW'(1)) begin
              busy   <= 1'b1;
              cp_idx <= '0;
            end
          end
          A_CMD: if (din == 16'h0020 || din == 16'h0030) begin
            lba_q  <= {b3_q, b2_q, b1_q, b0_q};
            len    <= new_len;
            rd_ptr <= '0;
            wr_ptr <= '0;
            cp_idx <= '0;
            dir_wr <= (din == 16'h0030);
            busy   <= (din == 16'h0020);
            drq    <= (din == 16'h0030);
          end
          default: ;
        endcase
      end
      if (rd_edge) begin
        case (addr)
          A_DATA: if (!busy && drq && !dir_wr) begin
            dout_q <= sbuf[rd_ptr[BIW-1:0]];
            rd_ptr <= rd_ptr + BAW'(1);
            if (rd_ptr == len - BAW'(1)) drq <= 1'b0;
          end else begin
            dout_q <= '0;
          end
          A_CMD:   dout_q <= {8'h00, status};
          default: dout_q <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && wr_edge && addr == A_DATA && drq && dir_wr)
      sbuf[wr_ptr[BIW-1:0]] <= din;
    if (busy && !dir_wr)
      sbuf[cp_idx[BIW-1:0]] <= in_range ? store[st_addr] : 16'h0000;
    if (busy && dir_wr && in_range)
      store[st_addr] <= sbuf[cp_idx[BIW-1:0]];
  end

endmodule

// File: rtl/ata_pio_target_chk.sv
module ata_pio_target_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dior_n,
  input logic [15:0]   dout,
  input logic          busy,
  input logic          drq,
  input logic          dir_wr,
  input logic [PW-1:0] rd_ptr,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] len
);
  logic seen_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_hi <= 1'b1;
    else        seen_hi <= dior_n;
  end

  a_r5_dout_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dior_n || !seen_hi) |=> $stable(dout));

  a_r5_rd_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= len);

  a_r6_wr_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= len);

  a_r4_load_hides_drq: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_wr) |-> !drq);

  a_r7_commit_keeps_drq: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_wr) |-> drq);

  a_r7_commit_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && dir_wr) |-> !drq);

  a_r4_load_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !dir_wr) |-> drq);

  a_r10_busy_freezes_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(rd_ptr) && $stable(wr_ptr)));
endmodule

bind ata_pio_target ata_pio_target_chk #(.PW(BAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dior_n(dior_n), .dout(dout),
  .busy(busy), .drq(drq), .dir_wr(dir_wr),
  .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .len(len)
);

// File: tb/test_ata_pio_target.sv
module test_ata_pio_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cs = 2'b00;
  logic [2:0]  da = 3'b000;
  logic        dior_n = 1'b1;
  logic        diow_n = 1'b1;
  logic [15:0] din = 16'h0000;
  logic [15:0] dout;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_w [512];

  always #5 clk = ~clk;

  ata_pio_target i_ata_pio_target (
    .clk(clk), .rst_n(rst_n), .cs(cs), .da(da),
    .dior_n(dior_n), .diow_n(diow_n), .din(din), .dout(dout)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [15:0] d, input int hold = 0);
    @(negedge clk);
    {cs, da} = a; din = d; diow_n = 1'b0;
    repeat (hold + 1) @(negedge clk);
    diow_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [15:0] d, input int hold = 0);
    @(negedge clk);
    {cs, da} = a; dior_n = 1'b0;
    @(negedge clk);
    d = dout;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R5 held output", dout, d);
    end
    dior_n = 1'b1;
  endtask

  task automatic stat_is(input string tag, input logic [7:0] exp);
    logic [15:0] v;
    bus_rd(5'h17, v);
    chk(tag, v, {8'h00, exp});
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int n = 0; n < 5000; n++) begin
      bus_rd(5'h17, v);
      if (!v[7]) break;
    end
  endtask

  function automatic logic [15:0] pat(input logic [15:0] seed, input int i);
    logic [15:0] k = 16'(i);
    return seed ^ (k * 16'h0103) ^ (k >> 3);
  endfunction

  task automatic set_tf(input logic [7:0] b3, b2, b1, b0, cnt);
    bus_wr(5'h16, {8'h00, b3});
    bus_wr(5'h15, {8'h00, b2});
    bus_wr(5'h14, {8'h00, b1});
    bus_wr(5'h13, {8'h00, b0});
    bus_wr(5'h12, {8'h00, cnt});
  endtask

  task automatic do_write(input int nw, input logic [15:0] seed);
    bus_wr(5'h17, 16'h0030);
    stat_is("R6 status after write cmd", 8'h58);
    for (int i = 0; i < nw; i++) begin
      if (i == nw - 1) stat_is("R8 not committed before last word", 8'h58);
      bus_wr(5'h10, pat(seed, i), (i == 0) ? 3 : 0);
    end
    stat_is("R7 status during write-back", 8'hD8);
    wait_ready();
    stat_is("R7 status after write-back", 8'h50);
  endtask

  task automatic do_read(input int nw, input string tag);
    logic [15:0] v;
    bus_wr(5'h17, 16'h0020);
    stat_is("R4 status during load", 8'hD0);
    wait_ready();
    stat_is("R4 status after load", 8'h58);
    for (int i = 0; i < nw; i++) begin
      bus_rd(5'h10, v, (i == 0) ? 3 : 0);
      chk(tag, v, exp_w[i]);
    end
    stat_is("R5 status after last word", 8'h50);
    bus_rd(5'h10, v);
    chk("R5 read past end", v, 16'h0000);
  endtask

  task automatic t_reset();
    chk("R2 dout after reset", dout, 16'h0000);
    stat_is("R2 status after reset", 8'h50);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    bus_wr(5'h0E, 16'h00FF);
    bus_wr(5'h1E, 16'h0006);
    bus_wr(5'h11, 16'h0003);
    bus_wr(5'h17, 16'h00EC);
    stat_is("R10 ignored writes and command", 8'h50);
    bus_wr(5'h12, 16'h0001);
    bus_rd(5'h12, v);
    chk("R1 other address reads zero", v, 16'h0000);
    bus_rd(5'h10, v);
    chk("R5 data read with no transfer", v, 16'h0000);
  endtask

  task automatic t_round_trip();
    set_tf(8'h00, 8'h00, 8'h00, 8'h02, 8'h01);
    do_write(256, 16'hA5C3);
    for (int i = 0; i < 256; i++) exp_w[i] = pat(16'hA5C3, i);
    do_read(256, "R4 round trip word");
  endtask

  task automatic t_lba_fields();
    set_tf(8'hF0, 8'h00, 8'h00, 8'h05, 8'h01);
    do_write(256, 16'h1234);
    set_tf(8'hA0, 8'h00, 8'h00, 8'h05, 8'h01);
    for (int i = 0; i < 256; i++) exp_w[i] = pat(16'h1234, i);
    do_read(256, "R3 high nibble ignored");
    set_tf(8'h00, 8'h00, 8'h01, 8'h05, 8'h01);
    do_write(256, 16'h7777);
    for (int i = 0; i < 256; i++) exp_w[i] = 16'h0000;
    do_read(256, "R9 out-of-range reads zero");
    set_tf(8'h01, 8'h00, 8'h00, 8'h02, 8'h01);
    do_write(256, 16'h5555);
    do_read(256, "R3 bits 27:24 used");
    set_tf(8'h00, 8'h00, 8'h00, 8'h02, 8'h01);
    for (int i = 0; i < 256; i++) exp_w[i] = pat(16'hA5C3, i);
    do_read(256, "R9 dropped write left sector");
  endtask

  task automatic t_clamp();
    set_tf(8'h00, 8'h00, 8'h00, 8'h06, 8'h03);
    do_write(512, 16'h0F0F);
    set_tf(8'h00, 8'h00, 8'h00, 8'h07, 8'h01);
    for (int i = 0; i < 256; i++) exp_w[i] = pat(16'h0F0F, i + 256);
    do_read(256, "R8 clamped second sector");
    set_tf(8'h00, 8'h00, 8'h00, 8'h07, 8'h02);
    for (int i = 256; i < 512; i++) exp_w[i] = 16'h0000;
    do_read(512, "R9 sector beyond store");
    set_tf(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    do_write(256, 16'hBEEF);
    for (int i = 0; i < 256; i++) exp_w[i] = pat(16'hBEEF, i);
    do_read(256, "R8 zero count one sector");
  endtask

  task automatic t_busy();
    logic [15:0] v;
    set_tf(8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    bus_wr(5'h17, 16'h0020);
    bus_wr(5'h17, 16'h0030);
    bus_wr(5'h13, 16'h0002);
    bus_rd(5'h10, v);
    chk("R10 data read while busy", v, 16'h0000);
    wait_ready();
    stat_is("R10 command ignored while busy", 8'h58);
    for (int i = 0; i < 256; i++) begin
      bus_rd(5'h10, v);
      chk("R10 load unaffected", v, pat(16'hBEEF, i));
    end
    stat_is("R5 drained", 8'h50);
    set_tf(8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    bus_wr(5'h12, 16'h0001);
    bus_wr(5'h17, 16'h0020);
    wait_ready();
    bus_rd(5'h10, v);
    chk("R10 sector reg kept", v, pat(16'hBEEF, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored();
    t_round_trip();
    t_lba_fields();
    t_clamp();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule